// File: doc/BRIEF.md
# Three-Code Combination Lock

This block is a lock controller with a small datapath. The lock opens only after three code values are entered in the right order. Each entry arrives on a value bus together with a single-cycle entry strobe. The three expected codes come in on one packed bus. A one-hot selector picks the code that is due next, and a comparator matches it against the entered value. A start pulse re-arms the lock from the beginning.

The controller is output-encoded. Its four state bits are the outputs themselves: one lock-open bit and a one-hot three-bit selector. The pattern with every bit low marks a failed entry. That failed state, like the open state, is left only through start. A state pattern outside the five legal codes is handled like the failed state.

Top module: `combo_lock`

## Requirements
- R1: One cycle after `start` is sampled high, the outputs read lockOpen=0 and codeSel=3'b001. This holds from any state, including open and failed.
- R2: Take a state with codeSel at 001, 010 or 100. An entry strobe whose value equals the selected code moves the lock one step: 001→010, 010→100, 100→open (lockOpen=1, codeSel=000). The outputs change one cycle after the strobe.
- R3: Take a state with codeSel at 001, 010 or 100. An entry strobe whose value differs from the selected code moves the lock to the failed state (lockOpen=0, codeSel=000) one cycle later.
- R4: While `entryStrobe` is low, the state does not change, whatever `entryValue` carries.
- R5: The open state (lockOpen=1, codeSel=000) stays put under any strobes and values until `start`.
- R6: The failed state (lockOpen=0, codeSel=000) stays put under any strobes and values, including a value equal to the first code, until `start`.
- R7: codeSel has at most one bit set. lockOpen is high only while codeSel is 000. The state bits always form one of the five legal patterns.
- R8: codeSel bit 0 selects `codeBus[3:0]`, bit 1 selects `codeBus[7:4]` and bit 2 selects `codeBus[11:8]`. A value that matches an unselected code counts as a mismatch.
- R9: When `start` and a matching entry strobe occur in the same cycle, `start` wins and the lock reads codeSel=001 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| start | input | 1 | Synchronous re-arm to the first step |
| entryStrobe | input | 1 | Single-cycle marker of a new entry |
| entryValue | input | 4 | Entered value |
| codeBus | input | 12 | First code in [3:0], second in [7:4], third in [11:8] |
| lockOpen | output | 1 | High when the lock is open |
| codeSel | output | 3 | One-hot selector of the code expected next |

## Verification
The hardest situations to reach are the sticky ones. One is a failed lock that receives the exact code that would have been correct at step one. Another is a value that matches a code other than the selected one. The stimulus table drives the lock into the failed state by presenting the second code while the first is selected. It then feeds the first code and confirms nothing moves. The table also issues start and a matching strobe together in the same cycle, to show that start wins.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int STEP_CNT = 3;
  localparam int STATE_W  = STEP_CNT + 1;

  typedef struct packed {
    logic [STEP_CNT-1:0] sel;
  } dpCtrl_t;

  typedef struct packed {
    logic match;
  } dpStat_t;

  localparam logic [STATE_W-1:0] ST_FIRST = STATE_W'(1);
  localparam logic [STATE_W-1:0] ST_ERR   = '0;
endpackage

// File: rtl/lock_datapath.sv
module lock_datapath
  import lock_pkg::*;
#(
  parameter int VAL_W = 4
) (
  input  logic                      clk,
  input  dpCtrl_t                   dpCtrl,
  input  logic [VAL_W-1:0]          entryValue,
  input  logic [STEP_CNT*VAL_W-1:0] codeBus,
  output dpStat_t                   dpStat
);
  logic [STEP_CNT-1:0][VAL_W-1:0] maskedCode;
  logic [VAL_W-1:0]               selCode;

  for (genvar g = 0; g < STEP_CNT; g++) begin : g_mask
    assign maskedCode[g] = codeBus[g*VAL_W +: VAL_W] & {VAL_W{dpCtrl.sel[g]}};
  end

  always_comb begin
    selCode = '0;
    for (int i = 0; i < STEP_CNT; i++) begin
      selCode = selCode | maskedCode[i];
    end
  end

  assign dpStat.match = (selCode == entryValue);

  // R7
  sel_onehot_chk: assert property (@(posedge clk)
    disable iff ($isunknown(dpCtrl.sel)) $onehot0(dpCtrl.sel));
endmodule

// File: rtl/lock_control.sv
module lock_control
  import lock_pkg::*;
(
  input  logic    clk,
  input  logic    start,
  input  logic    entryStrobe,
  input  dpStat_t dpStat,
  output dpCtrl_t dpCtrl,
  output logic    lockOpen
);
  localparam int OPEN_BIT = STATE_W - 1;

  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] stateD;
  logic               legal;
  logic               stepping;

  assign legal    = ~|(stateQ & (stateQ - 1'b1));
  assign stepping = |stateQ[STEP_CNT-1:0];

  always_comb begin
    stateD = stateQ;
    if (start) begin
      stateD = ST_FIRST;
    end else if (!legal || stateQ == ST_ERR) begin
      stateD = ST_ERR;
    end else if (stateQ[OPEN_BIT]) begin
      stateD = stateQ;
    end else if (entryStrobe) begin
      stateD = dpStat.match ? (stateQ << 1) : ST_ERR;
    end
  end

  always_ff @(posedge clk) begin
    stateQ <= stateD;
  end

  assign dpCtrl.sel = stateQ[STEP_CNT-1:0];
  assign lockOpen   = stateQ[OPEN_BIT];

  // Assertion-only qualifier: becomes high after the first start.
  logic armedQ;
  always_ff @(posedge clk) begin
    armedQ <= (armedQ === 1'b1) | start;
  end

  // R1
  start_first_chk: assert property (@(posedge clk)
    disable iff (armedQ !== 1'b1) start |=> stateQ == ST_FIRST);

  // R2
  advance_chk: assert property (@(posedge clk)
    disable iff (armedQ !== 1'b1)
    !start && entryStrobe && dpStat.match && stepping |=> stateQ == ($past(stateQ) << 1));

  // R3
  mismatch_err_chk: assert property (@(posedge clk)
    disable iff (armedQ !== 1'b1)
    !start && entryStrobe && !dpStat.match && stepping |=> stateQ == ST_ERR);

  // R4
  idle_hold_chk: assert property (@(posedge clk)
    disable iff (armedQ !== 1'b1) !start && !entryStrobe |=> $stable(stateQ));

  // R5
  open_sticky_chk: assert property (@(posedge clk)
    disable iff (armedQ !== 1'b1) !start && stateQ[OPEN_BIT] |=> stateQ[OPEN_BIT]);

  // R6
  err_sticky_chk: assert property (@(posedge clk)
    disable iff (armedQ !== 1'b1) !start && stateQ == ST_ERR |=> stateQ == ST_ERR);

  // R7
  state_legal_chk: assert property (@(posedge clk)
    disable iff (armedQ !== 1'b1) $onehot0(stateQ));
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import lock_pkg::*;
#(
  parameter int VAL_W = 4
) (
  input  logic                      clk,
  input  logic                      start,
  input  logic                      entryStrobe,
  input  logic [VAL_W-1:0]          entryValue,
  input  logic [STEP_CNT*VAL_W-1:0] codeBus,
  output logic                      lockOpen,
  output logic [STEP_CNT-1:0]       codeSel
);
  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  lock_control u_ctrl (
    .clk         (clk),
    .start       (start),
    .entryStrobe (entryStrobe),
    .dpStat      (dpStat),
    .dpCtrl      (dpCtrl),
    .lockOpen    (lockOpen)
  );

  lock_datapath #(.VAL_W(VAL_W)) u_dp (
    .clk        (clk),
    .dpCtrl     (dpCtrl),
    .entryValue (entryValue),
    .codeBus    (codeBus),
    .dpStat     (dpStat)
  );

  assign codeSel = dpCtrl.sel;
endmodule

// File: tb/combo_lock_tb.sv
module combo_lock_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;

  logic        clk = 1'b0;
  logic        start = 1'b0;
  logic        entryStrobe = 1'b0;
  logic [3:0]  entryValue = '0;
  logic [11:0] codeBus = 12'h5A3;   // first 3, second A, third 5
  logic        lockOpen;
  logic [2:0]  codeSel;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  combo_lock dut_i (
    .clk(clk), .start(start), .entryStrobe(entryStrobe), .entryValue(entryValue),
    .codeBus(codeBus), .lockOpen(lockOpen), .codeSel(codeSel)
  );

  // row: {start, strobe, value[3:0], expOpen, expSel[2:0], reqNum[3:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 4'h0, 1'b0, 3'b001, 4'd1},  // R1 re-arm
    {1'b0, 1'b0, 4'h3, 1'b0, 3'b001, 4'd4},  // R4 match without strobe
    {1'b0, 1'b1, 4'h3, 1'b0, 3'b010, 4'd2},  // R2 step 1
    {1'b0, 1'b0, 4'h0, 1'b0, 3'b010, 4'd4},  // R4 hold
    {1'b0, 1'b1, 4'hA, 1'b0, 3'b100, 4'd2},  // R2 step 2
    {1'b0, 1'b1, 4'h5, 1'b1, 3'b000, 4'd2},  // R2 open
    {1'b0, 1'b1, 4'h7, 1'b1, 3'b000, 4'd5},  // R5 stays open
    {1'b0, 1'b0, 4'h0, 1'b1, 3'b000, 4'd5},  // R5
    {1'b1, 1'b0, 4'h0, 1'b0, 3'b001, 4'd1},  // R1 from open
    {1'b0, 1'b1, 4'hA, 1'b0, 3'b000, 4'd8},  // R8 unselected code
    {1'b0, 1'b1, 4'h3, 1'b0, 3'b000, 4'd6},  // R6 first code ignored
    {1'b0, 1'b0, 4'h3, 1'b0, 3'b000, 4'd6},  // R6
    {1'b1, 1'b0, 4'h0, 1'b0, 3'b001, 4'd1},  // R1 from failed
    {1'b0, 1'b1, 4'h3, 1'b0, 3'b010, 4'd2},  // R2
    {1'b0, 1'b1, 4'h4, 1'b0, 3'b000, 4'd3},  // R3 wrong second
    {1'b1, 1'b1, 4'h3, 1'b0, 3'b001, 4'd9},  // R9 start beats strobe
    {1'b0, 1'b1, 4'h3, 1'b0, 3'b010, 4'd2},  // R2
    {1'b0, 1'b1, 4'hA, 1'b0, 3'b100, 4'd2},  // R2
    {1'b0, 1'b1, 4'h3, 1'b0, 3'b000, 4'd3},  // R3 wrong third
    {1'b1, 1'b0, 4'h0, 1'b0, 3'b001, 4'd1},  // R1
    {1'b0, 1'b1, 4'h0, 1'b0, 3'b000, 4'd3}   // R3 wrong first
  };

  task automatic step(input logic st, input logic nw, input logic [3:0] v);
    @(negedge clk);
    start = st; entryStrobe = nw; entryValue = v;
    @(posedge clk);
    #1;
    start = 1'b0; entryStrobe = 1'b0;
  endtask

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual open/sel=%b expected %b", req, act, exp);
    end
  endtask

  initial begin
    // reset state after first start (R1)
    step(1'b1, 1'b0, 4'h0);
    check({lockOpen, codeSel}, 4'b0001, 1);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][13], VEC[i][12], VEC[i][11:8]);
      check({lockOpen, codeSel}, VEC[i][7:4], int'(VEC[i][3:0]));
      // R7: open excludes any select bit, select at most one-hot
      check({lockOpen && (codeSel != 3'b000), ($countones(codeSel) > 1), 2'b00}, 4'b0000, 7);
    end

    // R4: long idle with wandering values in the second step
    step(1'b1, 1'b0, 4'h0);
    step(1'b0, 1'b1, 4'h3);
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 1'b0, 4'(k * 3));
      check({lockOpen, codeSel}, 4'b0010, 4);
    end

    // R8: new code set, including all-zero and all-ones codes
    codeBus = 12'hF09;
    step(1'b1, 1'b0, 4'h0);
    step(1'b0, 1'b1, 4'h9);
    check({lockOpen, codeSel}, 4'b0010, 8);
    step(1'b0, 1'b1, 4'h0);
    check({lockOpen, codeSel}, 4'b0100, 8);
    step(1'b0, 1'b1, 4'hF);
    check({lockOpen, codeSel}, 4'b1000, 2);

    // R9: start with a mismatching strobe still re-arms
    step(1'b1, 1'b1, 4'h1);
    check({lockOpen, codeSel}, 4'b0001, 9);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule